// File: doc/BRIEF.md
# Optimal Direction Selector

This block inspects a 5x5 neighbourhood of 8-bit grey levels and decides along which of four lines through the centre the picture is most uniform. For every line it takes the four neighbours that lie on it (two on each side of the centre, the centre itself left out), orders them from smallest to largest, throws away the smallest and the largest, and measures how far apart the two survivors are. The line whose survivors are closest together wins, and the block reports its code and its two surviving values.

A window producer upstream presents one complete window per cycle with a valid strobe; the selector is fully pipelined, so it accepts a new window every cycle and returns each answer a fixed four cycles later. A downstream impulse-noise stage would use the chosen direction and its two trimmed values to judge and repair the centre pixel; that stage is not part of this block.

Top module: `odsel_top`

## Requirements
- R1: `best_valid` is high exactly four rising clock edges after the edge that sampled `win_valid` high, and low otherwise.
- R2: The centre pixel (row 2, column 2) has no effect on any output.
- R3: `best_lo` and `best_hi` are the second smallest and second largest of the four neighbours on the chosen line, so `best_lo <= best_hi`; a 0 or 255 impulse at either end of the line is discarded.
- R4: The spread `best_hi - best_lo` of the reported line is no larger than the spread of the trimmed pair of any of the other three lines of the same window.
- R5: When several lines share the smallest spread, the lowest code among them is reported.
- R6: Pixel at row r, column c sits in `win_pix[(5*r+c)*8 +: 8]`; code 0 is the row through the centre (columns 0,1,3,4 of row 2), code 1 the column through the centre (rows 0,1,3,4 of column 2), code 2 the diagonal (0,0),(1,1),(3,3),(4,4), code 3 the anti-diagonal (0,4),(1,3),(3,1),(4,0).
- R7: Pixels lying on none of the four lines have no effect on any output.
- R8: While reset is asserted, all outputs are zero.
- R9: Windows on consecutive cycles each produce their own result on consecutive cycles, with no stall or loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | 1 | A window is present on `win_pix` this cycle |
| win_pix | input | 200 | 25 unsigned 8-bit pixels, row-major, pixel (r,c) at bits (5r+c)*8 upward |
| best_dir | output | 2 | Code of the line of least spread |
| best_lo | output | 8 | Smaller surviving value of the chosen line |
| best_hi | output | 8 | Larger surviving value of the chosen line |
| best_valid | output | 1 | Result fields are meaningful this cycle |

## Verification
A sorter stage that swaps or drops a value shows up four cycles after the window as a wrong `best_lo`/`best_hi` pair or a pair out of order, and because the reported spread then no longer matches the true trimmed spread it often also flips `best_dir`. A fault in the selection shows on that same cycle as a direction whose spread is beaten by another line or, on ties, as a code higher than necessary; a small pixel alphabet makes ties frequent enough to expose it. A slip in the valid pipeline appears as a strobe one cycle early or late against the windows that were sent, visible on the very first result.

// File: rtl/odsel_pkg.sv
package odsel_pkg;

  localparam int WIN  = 5;
  localparam int RAD  = (WIN - 1) / 2;
  localparam int TAPS = 2 * RAD;
  localparam int NDIR = 4;
  localparam int NPIX = WIN * WIN;

  typedef enum logic [1:0] {
    DIR_ROW  = 2'd0,
    DIR_COL  = 2'd1,
    DIR_DIAG = 2'd2,
    DIR_ANTI = 2'd3
  } dir_e;

  // signed distance from the centre for tap idx (centre skipped)
  function automatic int tap_dist(input int idx);
    return (idx < RAD) ? (idx - RAD) : (idx - RAD + 1);
  endfunction

  // flat pixel index of tap idx on line dir
  function automatic int tap_index(input int dir, input int idx);
    int d;
    int ro;
    int co;
    d = tap_dist(idx);
    case (dir)
      0:       begin ro = 0; co = d;  end
      1:       begin ro = d; co = 0;  end
      2:       begin ro = d; co = d;  end
      default: begin ro = d; co = -d; end
    endcase
    return (RAD + ro) * WIN + (RAD + co);
  endfunction

endpackage

// File: rtl/odsel_line_tap.sv
module odsel_line_tap
  import odsel_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int DIR   = 0
) (
  input  logic [NPIX*PIX_W-1:0]        win_pix,
  output logic [TAPS-1:0][PIX_W-1:0]   taps
);

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    localparam int POS = tap_index(DIR, t);
    assign taps[t] = win_pix[POS*PIX_W +: PIX_W];
  end

endmodule

// File: rtl/odsel_sort4.sv
module odsel_sort4 #(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [3:0][W-1:0]  in_vals,
  output logic               out_valid,
  output logic [W-1:0]       out_lo,
  output logic [W-1:0]       out_hi,
  output logic [W-1:0]       out_span
);

  function automatic logic [W-1:0] lesser(input logic [W-1:0] a, input logic [W-1:0] b);
    return (b < a) ? b : a;
  endfunction

  function automatic logic [W-1:0] greater(input logic [W-1:0] a, input logic [W-1:0] b);
    return (b < a) ? a : b;
  endfunction

  function automatic logic [W-1:0] gap(input logic [W-1:0] lo, input logic [W-1:0] hi);
    return hi - lo;
  endfunction

  logic [3:0][W-1:0] s1_q;
  logic [3:0][W-1:0] s2_q;
  logic              v1_q;
  logic              v2_q;
  logic [W-1:0]      mid_lo;
  logic [W-1:0]      mid_hi;

  // layer 3: only the two inner values survive; ends are dropped
  assign mid_lo = lesser(s2_q[1], s2_q[2]);
  assign mid_hi = greater(s2_q[1], s2_q[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q      <= '0;
      s2_q      <= '0;
      v1_q      <= 1'b0;
      v2_q      <= 1'b0;
      out_valid <= 1'b0;
      out_lo    <= '0;
      out_hi    <= '0;
      out_span  <= '0;
    end else begin
      // layer 1: pairwise order
      v1_q    <= in_valid;
      s1_q[0] <= lesser(in_vals[0], in_vals[1]);
      s1_q[1] <= greater(in_vals[0], in_vals[1]);
      s1_q[2] <= lesser(in_vals[2], in_vals[3]);
      s1_q[3] <= greater(in_vals[2], in_vals[3]);
      // layer 2: global min/max to the ends
      v2_q    <= v1_q;
      s2_q[0] <= lesser(s1_q[0], s1_q[2]);
      s2_q[1] <= greater(s1_q[0], s1_q[2]);
      s2_q[2] <= lesser(s1_q[1], s1_q[3]);
      s2_q[3] <= greater(s1_q[1], s1_q[3]);
      // layer 3 result plus spread
      out_valid <= v2_q;
      out_lo    <= mid_lo;
      out_hi    <= mid_hi;
      out_span  <= gap(mid_lo, mid_hi);
    end
  end

endmodule

// File: rtl/odsel_pick.sv
module odsel_pick
  import odsel_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [NDIR-1:0][W-1:0] in_lo,
  input  logic [NDIR-1:0][W-1:0] in_hi,
  input  logic [NDIR-1:0][W-1:0] in_span,
  output logic [1:0]             out_dir,
  output logic [W-1:0]           out_lo,
  output logic [W-1:0]           out_hi,
  output logic                   out_valid
);

  logic [1:0]   win_dir;
  logic [W-1:0] win_span;

  // strict compare keeps the earliest (lowest) code on equal spread
  always_comb begin
    win_dir  = 2'd0;
    win_span = in_span[0];
    for (int k = 1; k < NDIR; k++) begin
      if (in_span[k] < win_span) begin
        win_dir  = 2'(k);
        win_span = in_span[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_dir   <= '0;
      out_lo    <= '0;
      out_hi    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_dir   <= win_dir;
      out_lo    <= in_lo[win_dir];
      out_hi    <= in_hi[win_dir];
    end
  end

endmodule

// File: rtl/odsel_top.sv
module odsel_top
  import odsel_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  win_valid,
  input  logic [NPIX*PIX_W-1:0] win_pix,
  output logic [1:0]            best_dir,
  output logic [PIX_W-1:0]      best_lo,
  output logic [PIX_W-1:0]      best_hi,
  output logic                  best_valid
);

  logic [NDIR-1:0]                 dir_valid;
  logic [NDIR-1:0][PIX_W-1:0]      dir_lo;
  logic [NDIR-1:0][PIX_W-1:0]      dir_hi;

  // named internal events for the checker
  logic                            mid_valid;
  logic [NDIR-1:0][PIX_W-1:0]      mid_span;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [TAPS-1:0][PIX_W-1:0] line_px;

    odsel_line_tap #(.PIX_W(PIX_W), .DIR(d)) u_tap (
      .win_pix (win_pix),
      .taps    (line_px)
    );

    odsel_sort4 #(.W(PIX_W)) u_sort (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (win_valid),
      .in_vals   (line_px),
      .out_valid (dir_valid[d]),
      .out_lo    (dir_lo[d]),
      .out_hi    (dir_hi[d]),
      .out_span  (mid_span[d])
    );
  end

  assign mid_valid = dir_valid[0];

  odsel_pick #(.W(PIX_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (mid_valid),
    .in_lo     (dir_lo),
    .in_hi     (dir_hi),
    .in_span   (mid_span),
    .out_dir   (best_dir),
    .out_lo    (best_lo),
    .out_hi    (best_hi),
    .out_valid (best_valid)
  );

endmodule

// File: rtl/odsel_chk.sv
module odsel_chk
  import odsel_pkg::*;
#(
  parameter int W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic [1:0]             out_dir,
  input logic [W-1:0]           out_lo,
  input logic [W-1:0]           out_hi,
  input logic                   mid_valid,
  input logic [NDIR-1:0][W-1:0] mid_span
);

  logic [2:0]                   age;
  logic [NDIR-1:0][W-1:0]       prev_span;
  logic [W-1:0]                 out_span;
  logic                         lower_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age       <= '0;
      prev_span <= '0;
    end else begin
      if (age != 3'd7) age <= age + 3'd1;
      prev_span <= mid_span;
    end
  end

  assign out_span = out_hi - out_lo;

  always_comb begin
    lower_hit = 1'b0;
    for (int k = 0; k < NDIR; k++) begin
      if ((2'(k) < out_dir) && (prev_span[k] <= out_span)) lower_hit = 1'b1;
    end
  end

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R9
  pipe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1) |-> (out_valid == $past(mid_valid)));

  // R3
  span_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lo <= out_hi));

  // R4
  min_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_span <= prev_span[0]) && (out_span <= prev_span[1]) &&
                   (out_span <= prev_span[2]) && (out_span <= prev_span[3])));

  // R5
  tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !lower_hit);

endmodule

bind odsel_top odsel_chk #(.W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (win_valid),
  .out_valid (best_valid),
  .out_dir   (best_dir),
  .out_lo    (best_lo),
  .out_hi    (best_hi),
  .mid_valid (mid_valid),
  .mid_span  (mid_span)
);

// File: tb/odsel_top_bench.sv
module odsel_top_bench;

  localparam int PW = 8;
  localparam int NP = 25;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              win_valid = 1'b0;
  logic [NP*PW-1:0]  win_pix = '0;
  logic [1:0]        best_dir;
  logic [PW-1:0]     best_lo;
  logic [PW-1:0]     best_hi;
  logic              best_valid;

  odsel_top #(.PIX_W(PW)) u_odsel_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_valid  (win_valid),
    .win_pix    (win_pix),
    .best_dir   (best_dir),
    .best_lo    (best_lo),
    .best_hi    (best_hi),
    .best_valid (best_valid)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [7:0] px [NP];
  logic [31:0] rng = 32'h1F2E_3D4C;

  typedef struct {
    bit         v;
    logic [1:0] d;
    logic [7:0] lo;
    logic [7:0] hi;
    string      tag;
  } exp_t;
  exp_t pipe [4];

  function automatic logic [31:0] rnd();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  // line membership per R6, written as flat row-major positions
  function automatic int bpos(input int d, input int i);
    int tbl [16] = '{10, 11, 13, 14, 2, 7, 17, 22, 0, 6, 18, 24, 4, 8, 16, 20};
    return tbl[d*4 + i];
  endfunction

  function automatic bit on_line(input int p);
    for (int d = 0; d < 4; d++)
      for (int i = 0; i < 4; i++)
        if (bpos(d, i) == p) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model(output logic [1:0] bd, output logic [7:0] blo, output logic [7:0] bhi);
    int best;
    best = 1000;
    bd = 0; blo = 0; bhi = 0;
    for (int d = 0; d < 4; d++) begin
      int v [4];
      for (int i = 0; i < 4; i++) v[i] = px[bpos(d, i)];
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3 - a; b++)
          if (v[b] > v[b+1]) begin int t; t = v[b]; v[b] = v[b+1]; v[b+1] = t; end
      if (v[2] - v[1] < best) begin
        best = v[2] - v[1];
        bd   = 2'(d);
        blo  = 8'(v[1]);
        bhi  = 8'(v[2]);
      end
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input string tag);
    @(negedge clk);
    check("R1/R9", "valid", int'(best_valid), int'(pipe[3].v));
    if (pipe[3].v) begin
      check(pipe[3].tag, "direction", int'(best_dir), int'(pipe[3].d));
      check("R3", "low survivor", int'(best_lo), int'(pipe[3].lo));
      check("R3", "high survivor", int'(best_hi), int'(pipe[3].hi));
    end
    for (int k = 3; k > 0; k--) pipe[k] = pipe[k-1];
    pipe[0].v   = v;
    pipe[0].tag = tag;
    model(pipe[0].d, pipe[0].lo, pipe[0].hi);
    win_valid = v;
    for (int p = 0; p < NP; p++) win_pix[p*PW +: PW] = px[p];
  endtask

  task automatic set_line(input int d, input int a, input int b, input int c, input int e);
    px[bpos(d, 0)] = 8'(a);
    px[bpos(d, 1)] = 8'(b);
    px[bpos(d, 2)] = 8'(c);
    px[bpos(d, 3)] = 8'(e);
  endtask

  task automatic fill(input int mask);
    for (int p = 0; p < NP; p++) px[p] = 8'(rnd()) & 8'(mask);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      pipe[k].v = 1'b0; pipe[k].d = 0; pipe[k].lo = 0; pipe[k].hi = 0; pipe[k].tag = "R1";
    end
    for (int p = 0; p < NP; p++) px[p] = 8'hA5;
    win_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset holds every output at zero even with a window present
    check("R8", "valid in reset", int'(best_valid), 0);
    check("R8", "dir in reset", int'(best_dir), 0);
    check("R8", "lo in reset", int'(best_lo), 0);
    check("R8", "hi in reset", int'(best_hi), 0);
    win_valid = 1'b0;
    rst_n = 1'b1;

    // R6: each line wins when it alone is tight
    fill(255);
    set_line(0, 0, 50, 100, 200); set_line(1, 10, 30, 60, 90);
    set_line(2, 5, 6, 7, 100);    set_line(3, 0, 0, 255, 255);
    step(1, "R6");
    set_line(3, 70, 72, 71, 3);   set_line(2, 0, 60, 120, 180);
    step(1, "R6");
    set_line(1, 9, 250, 9, 9);
    step(1, "R6");
    // R3: impulses at the ends are dropped
    fill(255);
    set_line(0, 0, 40, 255, 41); set_line(1, 0, 0, 200, 255);
    set_line(2, 255, 10, 90, 0); set_line(3, 20, 255, 80, 0);
    step(1, "R3");
    // R5: flat window and partial ties
    for (int p = 0; p < NP; p++) px[p] = 8'd0;
    step(1, "R5");
    for (int p = 0; p < NP; p++) px[p] = 8'd255;
    step(1, "R5");
    set_line(0, 0, 100, 200, 255); set_line(1, 0, 90, 200, 255);
    set_line(2, 0, 40, 45, 255);   set_line(3, 9, 50, 55, 250);
    step(1, "R5");
    step(0, "R1");
    step(0, "R1");

    // R4: wide random windows with gaps in the valid stream
    for (int n = 0; n < 4000; n++) begin
      fill(255);
      step(rnd() % 4 != 0, "R4");
    end
    // R5 and R9: tiny alphabet makes ties common, back-to-back windows
    for (int n = 0; n < 4000; n++) begin
      fill(3);
      step(1, "R5");
    end
    // R2 and R7: fixed lines, only centre and off-line pixels move
    fill(255);
    for (int n = 0; n < 300; n++) begin
      for (int p = 0; p < NP; p++)
        if (!on_line(p)) px[p] = 8'(rnd());
      step(1, (n % 2 == 0) ? "R2" : "R7");
    end
    for (int n = 0; n < 6; n++) step(0, "R1");

    summary();
    $finish;
  end

endmodule